// File: doc/BRIEF.md
# Tach Period Range Monitor

This block watches the period measurements that a tachometer capture stage produces and decides whether each one is inside a programmed window. A period longer than the upper bound marks an overrun, which points to a slow or stalled fan. A period shorter than the lower bound marks an underrun, which points to a fan that runs too fast. The block also takes a counter-overflow flag from the capture stage. Each of the three events sets a sticky status bit. The period that caused the most recent range error is held next to the status bits so that software can read it. An interrupt is raised for any pending event whose enable bit is set.

Software works through a small word-addressed register interface. Threshold and control writes go to shadow copies. The monitor uses a separate active copy, and writing the control register with its load bit set moves the shadow values into the active copy. Stop-on-error freezes the monitor after the first range error until software clears that error. This keeps the first offending period for inspection.

Top module: `tach_range_mon`

## Requirements
- R1: After reset, word 0 (upper bound) reads 4, word 1 (lower bound) reads 1, word 2 (interrupt enables), word 3 (control) and word 4 (status) read 0, and `irq` is low.
- R2: The bound registers are TH_W (24) bits wide. Bits above TH_W are dropped on a write and read back as 0.
- R3: Bound and control writes change only the shadow values, which is what a read returns. Writing word 3 with bit 0 set copies both bounds and the newly written control fields into the active copy used for comparison. Bit 0 reads back as 0.
- R4: A valid period greater than the active upper bound sets status bit 0. The period is also stored in status bits 8 and up, zero extended. Both are visible the cycle after the strobe. A period equal to the bound sets nothing.
- R5: A valid period less than the active lower bound sets status bit 1 and stores the period the same way. A period equal to the bound sets nothing.
- R6: A high `cnt_ovf` on a clock edge sets status bit 2.
- R7: Status bits are sticky. Writing word 4 clears each bit written as 1 and leaves bits written as 0 unchanged. A new event in the same cycle as its clear leaves the bit set. Clearing does not change the stored period.
- R8: `irq` is high exactly when some status bit 0, 1 or 2 is set and the word 2 bit at the same position is set. Writing 0 to word 2 drops `irq`.
- R9: When the active stop bit (word 3 bit 1) is set and status bit 0 or 1 is set, valid periods change neither the status nor the stored period. Once both bits are cleared, comparisons resume. With stop clear, the stored period follows the most recent range error.
- R10: Word 3 bit 2 (count mode) and bits 31:8 (monitor time) are held and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address (0 upper, 1 lower, 2 enables, 3 control, 4 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| per_vld | input | 1 | One-cycle strobe marking a completed period |
| per_val | input | PERIOD_W (19) | Measured period |
| cnt_ovf | input | 1 | Capture counter overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every period from 0 to 15 against several bound pairs, including equal bounds and a zero lower bound. It computes each expected status and stored period arithmetically. This catches an inclusive compare or a stored period that is not updated. Periods are strobed before and after a load pulse, so a design that compares against shadow values reports errors at the wrong time. Status clears are issued in the same cycle as a new event and with mixed masks, which exposes a clear that wins over a set or a clear that wipes neighbouring bits. Stop-on-error is checked by showing that later periods leave the first stored value untouched and that monitoring resumes after the clear. The interrupt is checked against each enable bit in turn, so a design with a wrong enable pairing raises or drops `irq` wrongly.

// File: rtl/tach_mon_pkg.sv
package tach_mon_pkg;
   localparam int          AW      = 3;
   localparam int          DW      = 32;
   localparam int          NSRC    = 3;
   localparam int          MT_W    = 24;
   localparam int          CAP_LSB = 8;

   localparam logic [AW-1:0] A_UPPER = 3'd0;
   localparam logic [AW-1:0] A_LOWER = 3'd1;
   localparam logic [AW-1:0] A_IEN   = 3'd2;
   localparam logic [AW-1:0] A_CTRL  = 3'd3;
   localparam logic [AW-1:0] A_STAT  = 3'd4;

   localparam int SRC_OVR = 0;
   localparam int SRC_UND = 1;
   localparam int SRC_OVF = 2;

   typedef struct packed {
      logic [MT_W-1:0] mon_time;
      logic            mode;
      logic            stop;
   } ctrl_t;
endpackage

// File: rtl/tach_mon_regs.sv
module tach_mon_regs
   import tach_mon_pkg::*;
#(
   parameter int TH_W   = 24,
   parameter int UP_RST = 4,
   parameter int LO_RST = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [TH_W-1:0] up_sh,
   output logic [TH_W-1:0] lo_sh,
   output logic [TH_W-1:0] up_act,
   output logic [TH_W-1:0] lo_act,
   output logic [NSRC-1:0] ien,
   output ctrl_t           ctrl_sh,
   output ctrl_t           ctrl_act,
   output logic            load,
   output logic [NSRC-1:0] clr
);
   logic  wr_ctrl;
   ctrl_t ctrl_new;
   logic  unused_wbits;

   assign wr_ctrl  = we && (addr == A_CTRL);
   assign load     = wr_ctrl && wdata[0];
   assign ctrl_new = '{mon_time: wdata[DW-1:CAP_LSB], mode: wdata[2], stop: wdata[1]};
   assign clr      = (we && (addr == A_STAT)) ? wdata[NSRC-1:0] : '0;
   assign unused_wbits = ^wdata[CAP_LSB-1:NSRC];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_sh   <= TH_W'(UP_RST);
         lo_sh   <= TH_W'(LO_RST);
         ien     <= '0;
         ctrl_sh <= '0;
      end else if (we) begin
         case (addr)
            A_UPPER: up_sh   <= wdata[TH_W-1:0];
            A_LOWER: lo_sh   <= wdata[TH_W-1:0];
            A_IEN:   ien     <= wdata[NSRC-1:0];
            A_CTRL:  ctrl_sh <= ctrl_new;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_act   <= TH_W'(UP_RST);
         lo_act   <= TH_W'(LO_RST);
         ctrl_act <= '0;
      end else if (load) begin
         up_act   <= up_sh;
         lo_act   <= lo_sh;
         ctrl_act <= ctrl_new;
      end
   end

   // R3: active copy moves only on a load pulse
   a_r3_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(up_act) && $stable(lo_act) && $stable(ctrl_act)));
endmodule

// File: rtl/tach_mon_cmp.sv
module tach_mon_cmp #(
   parameter int PERIOD_W  = 19,
   parameter int TH_W      = 24,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld,
   input  logic                en,
   input  logic [PERIOD_W-1:0] per,
   input  logic [TH_W-1:0]     up,
   input  logic [TH_W-1:0]     lo,
   output logic                hit_ovr,
   output logic                hit_und
);
   localparam int CW = (PERIOD_W > TH_W) ? PERIOD_W : TH_W;

   logic [CW-1:0] p_x, u_x, l_x;
   logic          gt_up, lt_lo;

   assign p_x = CW'(per);
   assign u_x = CW'(up);
   assign l_x = CW'(lo);

   generate
      if (INCLUSIVE) begin : g_incl
         assign gt_up = (p_x >= u_x);
         assign lt_lo = (p_x <= l_x);
      end else begin : g_strict
         assign gt_up = (p_x > u_x);
         assign lt_lo = (p_x < l_x);
      end
   endgenerate

   assign hit_ovr = vld && en && gt_up;
   assign hit_und = vld && en && lt_lo;

   // R4/R5: no hit without a strobe
   a_r4_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ovr || hit_und) |-> (vld && en));
endmodule

// File: rtl/tach_mon_status.sv
module tach_mon_status #(
   parameter int PERIOD_W = 19,
   parameter int NSRC     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NSRC-1:0]     set,
   input  logic [NSRC-1:0]     clr,
   input  logic                cap_en,
   input  logic [PERIOD_W-1:0] cap_val,
   input  logic [NSRC-1:0]     ien,
   output logic [NSRC-1:0]     sts,
   output logic [PERIOD_W-1:0] cap,
   output logic                irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts <= '0;
         cap <= '0;
      end else begin
         sts <= (sts & ~clr) | set;
         if (cap_en) cap <= cap_val;
      end
   end

   assign irq = |(sts & ien);

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_chk
         // R7: a bit that is neither cleared nor set keeps its value
         a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[i] && !clr[i]) |=> sts[i]);
         // R7: a set in the cycle of a clear still wins
         a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> sts[i]);
      end
   endgenerate
endmodule

// File: rtl/tach_range_mon.sv
module tach_range_mon
   import tach_mon_pkg::*;
#(
   parameter int PERIOD_W  = 19,
   parameter int TH_W      = 24,
   parameter int UP_RST    = 4,
   parameter int LO_RST    = 1,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [2:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic                per_vld,
   input  logic [PERIOD_W-1:0] per_val,
   input  logic                cnt_ovf,
   output logic                irq
);
   localparam int CW = (PERIOD_W > TH_W) ? PERIOD_W : TH_W;

   initial begin
      assert (PERIOD_W >= 1 && PERIOD_W <= DW - CAP_LSB)
         else $error("PERIOD_W must lie in 1..24");
      assert (TH_W >= 1 && TH_W <= DW - CAP_LSB)
         else $error("TH_W must lie in 1..24");
   end

   logic [TH_W-1:0]     up_sh, lo_sh, up_act, lo_act;
   logic [NSRC-1:0]     ien, clr, set, sts;
   ctrl_t               ctrl_sh, ctrl_act;
   logic                load, cmp_en, hit_ovr, hit_und;
   logic [PERIOD_W-1:0] cap;
   logic                unused_act;

   assign unused_act = ctrl_act.mode ^ (^ctrl_act.mon_time);

   tach_mon_regs #(.TH_W(TH_W), .UP_RST(UP_RST), .LO_RST(LO_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .up_sh(up_sh), .lo_sh(lo_sh), .up_act(up_act), .lo_act(lo_act),
      .ien(ien), .ctrl_sh(ctrl_sh), .ctrl_act(ctrl_act), .load(load), .clr(clr)
   );

   assign cmp_en = !(ctrl_act.stop && (sts[SRC_OVR] || sts[SRC_UND]));

   tach_mon_cmp #(.PERIOD_W(PERIOD_W), .TH_W(TH_W), .INCLUSIVE(INCLUSIVE)) u_cmp (
      .clk(clk), .rst_n(rst_n), .vld(per_vld), .en(cmp_en), .per(per_val),
      .up(up_act), .lo(lo_act), .hit_ovr(hit_ovr), .hit_und(hit_und)
   );

   always_comb begin
      set          = '0;
      set[SRC_OVR] = hit_ovr;
      set[SRC_UND] = hit_und;
      set[SRC_OVF] = cnt_ovf;
   end

   tach_mon_status #(.PERIOD_W(PERIOD_W), .NSRC(NSRC)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(set), .clr(clr),
      .cap_en(hit_ovr || hit_und), .cap_val(per_val), .ien(ien),
      .sts(sts), .cap(cap), .irq(irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_UPPER: reg_rdata[TH_W-1:0] = up_sh;
         A_LOWER: reg_rdata[TH_W-1:0] = lo_sh;
         A_IEN:   reg_rdata[NSRC-1:0] = ien;
         A_CTRL: begin
            reg_rdata[DW-1:CAP_LSB] = ctrl_sh.mon_time;
            reg_rdata[2]            = ctrl_sh.mode;
            reg_rdata[1]            = ctrl_sh.stop;
         end
         A_STAT: begin
            reg_rdata[CAP_LSB +: PERIOD_W] = cap;
            reg_rdata[NSRC-1:0]            = sts;
         end
         default: ;
      endcase
   end

   logic [CW-1:0] pv_x, ua_x, la_x;
   assign pv_x = CW'(per_val);
   assign ua_x = CW'(up_act);
   assign la_x = CW'(lo_act);

   // R4: over the active upper bound sets overrun next cycle
   a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (per_vld && cmp_en && !INCLUSIVE && (pv_x > ua_x)) |=> sts[SRC_OVR]);
   // R5: under the active lower bound sets underrun next cycle
   a_r5_underrun: assert property (@(posedge clk) disable iff (!rst_n)
      (per_vld && cmp_en && !INCLUSIVE && (pv_x < la_x)) |=> sts[SRC_UND]);
   // R6: overflow flag always lands in status
   a_r6_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ovf |=> sts[SRC_OVF]);
   // R9: a frozen monitor keeps its range status and stored period
   a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_act.stop && (sts[SRC_OVR] || sts[SRC_UND]) && !clr[SRC_OVR] && !clr[SRC_UND])
      |=> ($stable(cap) && sts[SRC_OVR] == $past(sts[SRC_OVR]) && sts[SRC_UND] == $past(sts[SRC_UND])));
endmodule

// File: tb/tach_range_mon_tb.sv
module tach_range_mon_tb;
   localparam int PW = 19;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_we;
   logic [2:0]    reg_addr;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;
   logic          per_vld;
   logic [PW-1:0] per_val;
   logic          cnt_ovf;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tach_range_mon u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_vld(per_vld),
      .per_val(per_val), .cnt_ovf(cnt_ovf), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic strobe(input int p);
      @(negedge clk);
      per_vld = 1'b1; per_val = PW'(p);
      @(negedge clk);
      per_vld = 1'b0;
   endtask

   function automatic logic [31:0] st(input int cap, input logic [2:0] b);
      return (32'(cap) << 8) | 32'(b);
   endfunction

   task automatic chk_irq(input string req, input logic exp);
      #1;
      chk(req, 32'(irq), 32'(exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int ecap;
      int us[4] = '{5, 9, 3, 12};
      int ls[4] = '{2, 9, 0, 6};
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      per_vld = 1'b0; per_val = '0; cnt_ovf = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, d); chk("R1 upper", d, 32'd4);
      rd(3'd1, d); chk("R1 lower", d, 32'd1);
      rd(3'd2, d); chk("R1 ien", d, 32'd0);
      rd(3'd3, d); chk("R1 ctrl", d, 32'd0);
      rd(3'd4, d); chk("R1 status", d, 32'd0);
      chk_irq("R1 irq", 1'b0);

      // R2 width
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 upper width", d, 32'h00FF_FFFF);
      wr(3'd1, 32'hABCD_1234); rd(3'd1, d); chk("R2 lower width", d, 32'h00CD_1234);

      // R3 shadow vs active: active still 4/1
      wr(3'd0, 32'd10); wr(3'd1, 32'd1);
      strobe(7); rd(3'd4, d); chk("R3 before load", d, st(7, 3'b001));
      wr(3'd4, 32'h7);
      wr(3'd3, 32'h1); rd(3'd3, d); chk("R3 load bit reads 0", d, 32'd0);
      strobe(7); rd(3'd4, d); chk("R3 after load", d, st(7, 3'b000));
      ecap = 7;

      // R4 R5 sweep
      for (int k = 0; k < 4; k++) begin
         wr(3'd0, 32'(us[k])); wr(3'd1, 32'(ls[k])); wr(3'd3, 32'h1);
         for (int p = 0; p < 16; p++) begin
            logic [2:0] eb;
            eb = {1'b0, p < ls[k], p > us[k]};
            if (eb != 3'b000) ecap = p;
            strobe(p); rd(3'd4, d);
            chk($sformatf("R4/R5 sweep u=%0d l=%0d p=%0d", us[k], ls[k], p), d, st(ecap, eb));
            wr(3'd4, 32'h7);
         end
      end

      // R4 largest period (bounds now 12/6)
      strobe((1 << PW) - 1); rd(3'd4, d); chk("R4 max period", d, st((1 << PW) - 1, 3'b001));
      wr(3'd4, 32'h7); rd(3'd4, d); chk("R7 clear keeps period", d, st((1 << PW) - 1, 3'b000));

      // R6 overflow
      @(negedge clk); cnt_ovf = 1'b1; @(negedge clk); cnt_ovf = 1'b0;
      rd(3'd4, d); chk("R6 overflow", d, st((1 << PW) - 1, 3'b100));
      wr(3'd4, 32'h4);

      // R7 partial clears and set-wins
      strobe(20); strobe(2);
      rd(3'd4, d); chk("R7 both set", d, st(2, 3'b011));
      wr(3'd4, 32'h0); rd(3'd4, d); chk("R7 zero write keeps", d, st(2, 3'b011));
      wr(3'd4, 32'h2); rd(3'd4, d); chk("R7 clear underrun only", d, st(2, 3'b001));
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1; per_vld = 1'b1; per_val = PW'(30);
      @(negedge clk);
      reg_we = 1'b0; per_vld = 1'b0;
      rd(3'd4, d); chk("R7 set beats clear", d, st(30, 3'b001));

      // R8 interrupt
      chk_irq("R8 no enable", 1'b0);
      wr(3'd2, 32'h1); chk_irq("R8 overrun enabled", 1'b1);
      wr(3'd2, 32'h2); chk_irq("R8 wrong enable", 1'b0);
      wr(3'd2, 32'h4); chk_irq("R8 overflow enable idle", 1'b0);
      @(negedge clk); cnt_ovf = 1'b1; @(negedge clk); cnt_ovf = 1'b0;
      chk_irq("R8 overflow pending", 1'b1);
      wr(3'd2, 32'h0); chk_irq("R8 disable all", 1'b0);
      wr(3'd4, 32'h7); wr(3'd2, 32'h7); chk_irq("R8 cleared", 1'b0);
      strobe(1); chk_irq("R8 underrun irq", 1'b1);
      wr(3'd4, 32'h7); chk_irq("R8 clear drops irq", 1'b0);
      wr(3'd2, 32'h0);

      // R9 stop-on-error
      wr(3'd3, 32'h3);
      strobe(20); rd(3'd4, d); chk("R9 first error", d, st(20, 3'b001));
      strobe(40); rd(3'd4, d); chk("R9 frozen overrun", d, st(20, 3'b001));
      strobe(1);  rd(3'd4, d); chk("R9 frozen underrun", d, st(20, 3'b001));
      wr(3'd4, 32'h3);
      strobe(2);  rd(3'd4, d); chk("R9 resumes", d, st(2, 3'b010));
      wr(3'd3, 32'h1);
      strobe(25); rd(3'd4, d); chk("R9 no stop tracks latest", d, st(25, 3'b011));
      wr(3'd4, 32'h7);

      // R10 control fields held
      wr(3'd3, 32'hABCD_EF06); rd(3'd3, d); chk("R10 ctrl readback", d, 32'hABCD_EF06);
      strobe(50); strobe(60);
      rd(3'd4, d); chk("R10 stop not active without load", d, st(60, 3'b001));

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule